// File: doc/BRIEF.md
# Serial Flash Target with Byte Program

This block is the device side of a small serial flash memory. A host selects it by pulling the active-low chip select low, then clocks in a one-byte command, most significant bit first, on the rising edges of the serial clock. The block takes data from the serial input on rising clock edges and changes the serial output on falling clock edges. It decodes four commands:

- **0x03** reads a continuous stream of bytes.
- **0x06** sets the write-enable latch.
- **0x02** programs one byte.
- **0x05** streams the status byte.

The storage is an internal byte array of 2^ADDR_W entries. ADDR_W = 19 gives the full 512 KiB array. The default of 9 keeps simulation small. The serial pins are oversampled by the system clock, and every decision is made in that clock domain. A byte program is committed when chip select rises. The block then stays busy for PROG_CYCLES system clocks to model the self-timed array write.

Top module: `spi_flash_target`

## Requirements
- R1: After reset, so_oe is low, every array byte reads 0xFF, and the status byte is 0x00.
- R2: Command 0x03 is followed by a 24-bit address, most significant bit first. Only the low ADDR_W bits of the address are used. The byte at that address is then shifted out, bit 7 first, with so changing after each falling SCK edge.
- R3: A read continues until chip select rises. The address advances by one after each byte and wraps from 2^ADDR_W-1 to 0.
- R4: Command 0x02 is followed by a 24-bit address and one data byte. When chip select rises after exactly 40 bits, and the write-enable latch is set, the stored byte becomes the old value AND the new data. The write-enable latch clears when the program time ends.
- R5: A program sent while the write-enable latch is clear leaves the array unchanged.
- R6: A program whose address lies in PROT_LO..PROT_HI leaves both the array and the write-enable latch unchanged.
- R7: A command whose chip-select window ends before its full bit count has no effect. The full count is 8 bits for 0x06 and 40 bits for 0x02.
- R8: Command 0x05 streams the status byte, repeated for every byte. Bit 0 is busy and bit 1 is the write-enable latch. Busy is high from a program commit for PROG_CYCLES clocks.
- R9: so_oe stays low while a command and its address are shifted in, for the whole of a program command, and after chip select goes high.
- R10: Both clock idle levels are accepted: SCK low when chip select falls (mode 0) and SCK high when it falls (mode 3).
- R11: While busy, only command 0x05 is accepted. Read, write-enable and program commands are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host; valid only while so_oe is high |
| so_oe | output | 1 | Output enable for so; low means high impedance |

## Verification
On every cycle, the embedded assertions check the following:
- The output is released after deselect, and it never drives during a program command.
- Busy only begins with the write-enable latch set, and the latch is gone once busy ends.
- The program timer stays within its range.
- A read cannot be active while busy.

Only the directed scenarios can show the remaining behaviour: read data values, address wrap, the AND-style program result, and the rejection of protected, truncated, unenabled or busy-time commands. The bench observes these through later reads and status polls in both clock modes.

// File: rtl/spi_flash_target.sv
module spi_flash_target #(
  parameter int ADDR_W      = 9,
  parameter int PROT_LO     = 448,
  parameter int PROT_HI     = 511,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = $clog2(PROG_CYCLES + 1);
  localparam logic [ADDR_W-1:0] P_LO = PROT_LO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] P_HI = PROT_HI[ADDR_W-1:0];
  localparam logic [PW-1:0]     P_CNT = PW'(PROG_CYCLES);

  logic sck_r, sck_p, cs_r, cs_p, si_r;
  logic [5:0]        bits;
  logic [7:0]        sr, op, tx;
  logic [ADDR_W-1:0] addr, ptr;
  logic [2:0]        bidx;
  logic              so_q, oe_q, wel, busy;
  logic [PW-1:0]     pcnt;
  logic [7:0]        mem [DEPTH];

  wire rise    = sck_r & ~sck_p & ~cs_r;
  wire fall    = ~sck_r & sck_p & ~cs_r;
  wire end_cmd = cs_r & ~cs_p;
  wire [7:0]        sr_nx   = {sr[6:0], si_r};
  wire [ADDR_W-1:0] addr_nx = {addr[ADDR_W-2:0], si_r};
  wire rd_ph   = (op == 8'h03) && (bits >= 6'd32);
  wire st_ph   = (op == 8'h05) && (bits >= 6'd8);
  wire [7:0] status = {6'b0, wel, busy};
  wire prot    = (addr >= P_LO) && (addr <= P_HI);
  wire do_prog = end_cmd && (op == 8'h02) && (bits == 6'd40) && wel && !busy && !prot;
  wire [7:0] nbyte = rd_ph ? mem[ptr] : status;

  assign so    = so_q;
  assign so_oe = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_r <= 1'b0; sck_p <= 1'b0; cs_r <= 1'b1; cs_p <= 1'b1; si_r <= 1'b0;
    end else begin
      sck_r <= sck; sck_p <= sck_r; cs_r <= cs_n; cs_p <= cs_r; si_r <= si;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0; sr <= '0; op <= '0; addr <= '0; ptr <= '0;
      tx <= '0; bidx <= '0; so_q <= 1'b0; oe_q <= 1'b0;
    end else if (cs_r) begin
      bits <= '0; op <= '0; bidx <= '0; oe_q <= 1'b0;
    end else begin
      if (rise) begin
        sr <= sr_nx;
        if (bits != 6'd63) bits <= bits + 6'd1;
        if (bits == 6'd7) op <= (busy && sr_nx != 8'h05) ? 8'h00 : sr_nx;
        if (bits >= 6'd8 && bits <= 6'd31) addr <= addr_nx;
        if (bits == 6'd31) ptr <= addr_nx;
      end
      if (fall && (rd_ph || st_ph)) begin
        oe_q <= 1'b1;
        bidx <= bidx + 3'd1;
        if (bidx == 3'd0) begin
          so_q <= nbyte[7];
          tx   <= {nbyte[6:0], 1'b0};
          if (rd_ph) ptr <= ptr + 1'b1;
        end else begin
          so_q <= tx[7];
          tx   <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0; busy <= 1'b0; pcnt <= '0;
    end else if (busy) begin
      pcnt <= pcnt - 1'b1;
      if (pcnt == 1) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end
    end else if (do_prog) begin
      busy <= 1'b1;
      pcnt <= P_CNT;
    end else if (end_cmd && op == 8'h06 && bits == 6'd8) begin
      wel <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (do_prog) begin
      mem[addr] <= mem[addr] & sr;
    end
  end

  assert_release_on_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    end_cmd |=> !so_oe);
  assert_quiet_in_program_R9: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> op != 8'h02);
  assert_busy_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wel);
  assert_wel_gone_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  assert_timer_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pcnt != '0 && pcnt <= P_CNT));
  assert_no_read_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(op == 8'h03 && so_oe));
endmodule

// File: tb/tb_spi_flash_target.sv
`timescale 1ns/1ps
module tb_spi_flash_target;
  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, si = 0;
  logic so, so_oe;
  int total = 0, bad = 0;
  logic mode3 = 0, oe_seen = 0;
  logic [7:0] rb [8];
  logic [7:0] st;

  always #2 clk = ~clk;

  spi_flash_target dut (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
                        .si(si), .so(so), .so_oe(so_oe));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hcyc; repeat (6) @(negedge clk); endtask

  task automatic cs_lo;
    sck = mode3; hcyc; cs_n = 0; hcyc;
  endtask

  task automatic cs_hi;
    if (!mode3) begin sck = 0; hcyc; end
    cs_n = 1; repeat (10) @(negedge clk); sck = mode3; hcyc;
  endtask

  task automatic xbits(input logic [7:0] t, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 0; si = t[i]; hcyc;
      r[i] = so; if (so_oe) oe_seen = 1;
      sck = 1; hcyc;
    end
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    xbits(t, 8, r);
  endtask

  task automatic send_hdr(input logic [7:0] opc, input logic [23:0] a);
    logic [7:0] d;
    xbyte(opc, d); xbyte(a[23:16], d); xbyte(a[15:8], d); xbyte(a[7:0], d);
  endtask

  task automatic wren;
    logic [7:0] d;
    cs_lo; xbyte(8'h06, d); cs_hi;
  endtask

  task automatic prog(input logic [23:0] a, input logic [7:0] v);
    logic [7:0] d;
    cs_lo; oe_seen = 0; send_hdr(8'h02, a); xbyte(v, d); cs_hi;
    chk(!oe_seen, "R9 so_oe during program", oe_seen, 0);
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] d;
    cs_lo; xbyte(8'h05, d); xbyte(8'h00, s); cs_hi;
  endtask

  task automatic rd(input logic [23:0] a, input int n);
    cs_lo; oe_seen = 0; send_hdr(8'h03, a);
    chk(!oe_seen, "R9 so_oe during opcode/address", oe_seen, 0);
    for (int k = 0; k < n; k++) xbyte(8'h00, rb[k]);
    cs_hi;
  endtask

  task automatic t_reset;
    chk(so_oe == 0, "R1 so_oe after reset", so_oe, 0);
    rd_status(st); chk(st == 8'h00, "R1 status after reset", st, 8'h00);
    rd(24'h000000, 2);
    chk(rb[0] == 8'hFF, "R1 erased byte 0", rb[0], 8'hFF);
    chk(rb[1] == 8'hFF, "R2 erased byte 1", rb[1], 8'hFF);
    chk(so_oe == 0, "R9 so_oe after deselect", so_oe, 0);
  endtask

  task automatic t_program;
    wren; rd_status(st); chk(st == 8'h02, "R8 wel bit", st, 8'h02);
    prog(24'h000005, 8'hA5);
    rd_status(st); chk(st == 8'h03, "R8 busy bit during program", st, 8'h03);
    repeat (1200) @(negedge clk);
    rd_status(st); chk(st == 8'h00, "R4 wel cleared after program", st, 8'h00);
    rd(24'h000005, 1); chk(rb[0] == 8'hA5, "R4 programmed byte", rb[0], 8'hA5);
    prog(24'h000005, 8'h0F); repeat (1200) @(negedge clk);
    rd(24'h000005, 1); chk(rb[0] == 8'hA5, "R5 program without wel", rb[0], 8'hA5);
    wren; prog(24'h000005, 8'h0F); repeat (1200) @(negedge clk);
    rd(24'hFF0005, 1); chk(rb[0] == 8'h05, "R4 AND program, R2 high address bits", rb[0], 8'h05);
  endtask

  task automatic t_stream;
    wren; prog(24'h000000, 8'h3C); repeat (1200) @(negedge clk);
    rd(24'h0001FE, 4);
    chk(rb[0] == 8'hFF, "R3 byte 0x1FE", rb[0], 8'hFF);
    chk(rb[1] == 8'hFF, "R3 byte 0x1FF", rb[1], 8'hFF);
    chk(rb[2] == 8'h3C, "R3 wrap to 0", rb[2], 8'h3C);
    chk(rb[3] == 8'hFF, "R3 byte 1 after wrap", rb[3], 8'hFF);
  endtask

  task automatic t_protect;
    wren; prog(24'h0001FF, 8'h00); repeat (1200) @(negedge clk);
    rd(24'h0001FF, 1); chk(rb[0] == 8'hFF, "R6 protected byte unchanged", rb[0], 8'hFF);
    rd_status(st); chk(st == 8'h02, "R6 wel kept", st, 8'h02);
  endtask

  task automatic t_trunc;
    logic [7:0] d;
    cs_lo; send_hdr(8'h02, 24'h000007); cs_hi;
    repeat (100) @(negedge clk);
    rd(24'h000007, 1); chk(rb[0] == 8'hFF, "R7 truncated program", rb[0], 8'hFF);
    rd_status(st); chk(st == 8'h02, "R7 no busy after truncated program", st, 8'h02);
    prog(24'h000008, 8'h00); repeat (1200) @(negedge clk);
    rd_status(st); chk(st == 8'h00, "R4 wel cleared", st, 8'h00);
    cs_lo; xbits(8'h06, 5, d); cs_hi;
    rd_status(st); chk(st == 8'h00, "R7 truncated write enable", st, 8'h00);
  endtask

  task automatic t_busy;
    wren; prog(24'h000009, 8'h55);
    cs_lo; oe_seen = 0; send_hdr(8'h03, 24'h000009); xbyte(8'h00, rb[0]); cs_hi;
    chk(!oe_seen, "R11 read ignored while busy", oe_seen, 0);
    wren;
    repeat (1200) @(negedge clk);
    rd_status(st); chk(st == 8'h00, "R11 wren ignored while busy", st, 8'h00);
    rd(24'h000009, 1); chk(rb[0] == 8'h55, "R4 byte after busy", rb[0], 8'h55);
  endtask

  task automatic t_mode3;
    mode3 = 1; sck = 1; hcyc;
    rd(24'h000005, 2);
    chk(rb[0] == 8'h05, "R10 mode 3 read", rb[0], 8'h05);
    chk(rb[1] == 8'hFF, "R10 mode 3 next byte", rb[1], 8'hFF);
    wren; prog(24'h00000A, 8'h81); repeat (1200) @(negedge clk);
    rd(24'h00000A, 1); chk(rb[0] == 8'h81, "R10 mode 3 program", rb[0], 8'h81);
    mode3 = 0; sck = 0; hcyc;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset;
    t_program;
    t_stream;
    t_protect;
    t_trunc;
    t_busy;
    t_mode3;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule